// File: doc/BRIEF.md
# Filtered Pass-Window Edge Scanner

This block holds a vector of pass/fail results, one bit per delay tap, and searches it for the edges of the passing window. A bit equal to 1 means the tap passed. Glitch filtering is built into the edge rules. A pass only counts as a lower edge when several passes follow it. A failure only counts as an upper edge when several passes come before it. Isolated passes and short failure gaps at the start of a window are therefore skipped.

Software or a sequencer fills the vector one bit at a time through a write port. It then pulses `start` together with an edge type, a first tap and a last tap. The scanner tests one tap per clock, in ascending order, and stops at the first tap that meets the rule. It raises `done` for one cycle with either the tap index or a not-found indication.

A typical use needs two runs. The first run looks for a rising edge and begins at the filter depth. The second run looks for a falling edge and begins at the tap the first run returned. The caller then takes the midpoint of the two results.

Top module: `pass_window_scan`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_bit` at tap `wr_addr` of the internal vector. Other taps keep their values.
- R2: When `edge_fall` is 0 (rising), tap i qualifies when bit i is 1, bit i-1 is 0, and the SAMPLES bits i+1 to i+SAMPLES are all 1. The default SAMPLES is 3.
- R3: When `edge_fall` is 1 (falling), tap i qualifies when bit i is 0 and the SAMPLES bits i-1 to i-SAMPLES are all 1.
- R4: A tap below index 0 reads as 0. A rising edge can therefore be found at tap 0. A falling edge cannot be found at a tap below SAMPLES.
- R5: The scan covers taps from `start_idx` up to and including `max_idx` - SAMPLES. No tap outside this range is reported.
- R6: Of the taps in the range that qualify, the lowest is reported, and the scan stops at that tap.
- R7: When no tap qualifies, `found` is 0 and `result_idx` is all ones. This includes an empty range, where `start_idx` > `max_idx` - SAMPLES, or `max_idx` < SAMPLES.
- R8: Start is the edge at which `start` is sampled. Tap i is tested at edge i - `start_idx` + 1 after start. `done` rises one edge after the tap that decides the result, and it stays high for exactly one cycle. For an empty range, `done` rises at the second edge after start.
- R9: `start` has no effect while `busy` is high. While the block is idle, `found` and `result_idx` keep their last values until the next search completes.
- R10: After reset, `busy`, `done` and `found` are 0, `result_idx` is all ones, and every bit of the vector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one vector bit |
| wr_addr | input | IW | Tap index to write |
| wr_bit | input | 1 | Value written (1 = pass) |
| start | input | 1 | Launch a search (ignored while busy) |
| edge_fall | input | 1 | 0 = rising edge search, 1 = falling edge search |
| start_idx | input | IW | First tap tested |
| max_idx | input | IW | Upper tap bound; last tap tested is max_idx - SAMPLES |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at search completion |
| found | output | 1 | Last search found a qualifying tap |
| result_idx | output | IW | Tap found, or all ones when none |

## Verification
The bench goes after an isolated pass or a short pass run placed before a true window. A scanner that drops the look-ahead filter would return that glitch instead of the window start. It places the falling edge exactly on the last tap in range, and then one tap past it. An off-by-one range bound would either miss the edge or report a tap it must not reach. It covers windows touching tap 0, where a scanner that wraps negative indices to the top of the vector would reject or invent edges. It also covers empty ranges and a second `start` during a search. A scanner that reloads on that pulse would return the second search's answer at the wrong latency.

// File: rtl/pass_window_scan.sv
module pass_window_scan #(
  parameter int WIDTH   = 256,
  parameter int SAMPLES = 3,
  localparam int IW     = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          start,
  input  logic          edge_fall,
  input  logic [IW-1:0] start_idx,
  input  logic [IW-1:0] max_idx,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [IW-1:0] result_idx
);

  localparam int WW = 2 * SAMPLES + 1;
  localparam int PW = WIDTH + 2 * SAMPLES;
  localparam int CW = IW + 2;

  logic [WIDTH-1:0] vec_q;
  logic [IW-1:0]    cur_q, max_q;
  logic             fall_q, busy_q;
  logic [PW-1:0]    pad;
  logic [WW-1:0]    win;
  logic             hit, past_end;

  // zero guard bands on both sides, so taps outside the vector read 0
  assign pad = {{SAMPLES{1'b0}}, vec_q, {SAMPLES{1'b0}}};
  assign win = WW'(pad >> cur_q);

  assign hit = fall_q ? (!win[SAMPLES] && (&win[SAMPLES-1:0]))
                      : ( win[SAMPLES] && !win[SAMPLES-1] && (&win[2*SAMPLES:SAMPLES+1]));

  assign past_end = (CW'(cur_q) + CW'(SAMPLES)) > CW'(max_q);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (wr_en) vec_q[wr_addr] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      result_idx <= '1;
      cur_q      <= '0;
      max_q      <= '0;
      fall_q     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cur_q  <= start_idx;
          max_q  <= max_idx;
          fall_q <= edge_fall;
        end
      end else if (past_end) begin
        busy_q     <= 1'b0;
        done       <= 1'b1;
        found      <= 1'b0;
        result_idx <= '1;
      end else if (hit) begin
        busy_q     <= 1'b0;
        done       <= 1'b1;
        found      <= 1'b1;
        result_idx <= cur_q;
      end else begin
        cur_q <= cur_q + IW'(1);
      end
    end
  end

  p_found_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && found |-> (CW'(result_idx) + CW'(SAMPLES)) <= CW'(max_q));

  p_miss_all_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !found |-> result_idx == '1);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cur_q == $past(cur_q) + IW'(1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(result_idx) && $stable(found));

endmodule

// File: tb/pass_window_scan_bench.sv
module pass_window_scan_bench;
  localparam int W  = 256;
  localparam int S  = 3;
  localparam int IW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, start = 1'b0, edge_fall = 1'b0;
  logic [IW-1:0] wr_addr = '0, start_idx = '0, max_idx = '0;
  logic busy, done, found;
  logic [IW-1:0] result_idx;

  logic [W-1:0] mdl;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pass_window_scan #(.WIDTH(W), .SAMPLES(S)) u_pass_window_scan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .start(start), .edge_fall(edge_fall), .start_idx(start_idx), .max_idx(max_idx),
    .busy(busy), .done(done), .found(found), .result_idx(result_idx));

  function automatic bit getb(int i);
    if (i < 0 || i >= W) return 1'b0;
    return mdl[i];
  endfunction

  function automatic int ref_find(bit fall, int st, int mx);
    for (int i = st; i <= mx - S; i++) begin
      bit ok;
      if (fall) begin
        ok = !getb(i);
        for (int k = 1; k <= S; k++) ok = ok && getb(i - k);
      end else begin
        ok = getb(i) && !getb(i - 1);
        for (int k = 1; k <= S; k++) ok = ok && getb(i + k);
      end
      if (ok) return i;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < W; i++) begin
      wr_en = 1'b1; wr_addr = IW'(i); wr_bit = mdl[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic set_window(int lo, int hi);
    mdl = '0;
    for (int i = lo; i < hi; i++) mdl[i] = 1'b1;
  endtask

  task automatic search(bit fall, int st, int mx, string req, output int got);
    int r, lim, expn, cyc;
    r = ref_find(fall, st, mx);
    lim = mx - S;
    expn = (r >= 0) ? r - st + 1 : ((lim >= st) ? lim - st + 2 : 1);
    edge_fall = fall; start_idx = IW'(st); max_idx = IW'(mx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(found == (r >= 0), req, "found", int'(found), int'(r >= 0));
    check(int'(result_idx) == ((r >= 0) ? r : W - 1), req, "result_idx", int'(result_idx), (r >= 0) ? r : W - 1);
    check(cyc == expn + 1, "R8", "done latency", cyc, expn + 1);
    got = found ? int'(result_idx) : -1;
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
  endtask

  initial begin
    int g, lo;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !done && !found, "R10", "flags after reset", int'({busy, done, found}), 0);
    check(result_idx == '1, "R10", "idx after reset", int'(result_idx), W - 1);
    rst_n = 1'b1;
    @(negedge clk);
    mdl = '0;
    search(0, S, W - 1, "R10", g);

    set_window(20, 60);
    load_all();
    search(0, S, W - 1, "R1", g);
    search(1, g, W - 1, "R3", g);

    mdl[10] = 1'b1; mdl[12] = 1'b1; mdl[13] = 1'b1; mdl[14] = 1'b1;
    load_all();
    search(0, S, W - 1, "R2", g);
    check(g == 20, "R2", "glitch rejected", g, 20);

    mdl[22] = 1'b0;
    load_all();
    search(1, 20, W - 1, "R3", g);
    check(g == 60, "R3", "short gap rejected", g, 60);
    mdl[22] = 1'b1;
    load_all();

    search(1, 20, 63, "R5", g);
    check(g == 60, "R5", "edge at last tap", g, 60);
    search(1, 20, 62, "R5", g);
    check(g == -1, "R7", "edge past last tap", g, -1);
    search(0, S, 2, "R7", g);
    search(1, 100, 50, "R7", g);
    search(0, 25, 80, "R6", g);

    mdl = '0; mdl[0] = 1'b1;
    for (int i = 2; i < 7; i++) mdl[i] = 1'b1;
    load_all();
    search(1, 0, W - 1, "R4", g);
    check(g == 7, "R4", "falling at low end", g, 7);
    set_window(0, 10);
    load_all();
    search(0, 0, W - 1, "R4", g);
    check(g == 0, "R4", "rising at tap 0", g, 0);

    set_window(120, 200);
    load_all();
    begin
      int cyc;
      edge_fall = 0; start_idx = IW'(S); max_idx = IW'(W - 1); start = 1'b1;
      @(negedge clk);
      edge_fall = 1; start_idx = '0; max_idx = IW'(W - 1);
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
      check(found && result_idx == IW'(120), "R9", "start while busy", int'(result_idx), 120);
      check(cyc == 120 - S + 2, "R9", "latency unchanged", cyc, 120 - S + 2);
      repeat (5) @(negedge clk);
      check(found && result_idx == IW'(120), "R9", "result held", int'(result_idx), 120);
    end

    for (int t = 0; t < 40; t++) begin
      int hi, nf, st, mx;
      lo = S + int'($urandom_range(0, W / 2));
      hi = lo + 8 + int'($urandom_range(0, W / 3));
      if (hi > W - 8) hi = W - 8;
      set_window(lo, hi);
      nf = int'($urandom_range(0, 4));
      for (int k = 0; k < nf; k++) begin
        int p;
        p = int'($urandom_range(0, W - 1));
        mdl[p] = ~mdl[p];
      end
      load_all();
      search(0, S, W - 1, "R6", g);
      if (g >= 0) search(1, g, W - 1, "R3", g);
      st = int'($urandom_range(0, W - 1));
      mx = int'($urandom_range(0, W - 1));
      search(t[0], st, mx, "R5", g);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule